// File: doc/BRIEF.md
# Outbound Packet Header Formatter

This block sits on the transmit side of a baseband framework, between up to four application payload sources and the Ethernet transmitter. Each payload arrives as a byte stream with a port number and a payload byte count. The port number selects one entry of a small configuration table. That entry decides which headers go in front of the payload and supplies the values those headers carry. The block writes the finished frame out byte by byte, destination MAC first.

Every frame starts with a 14-byte Ethernet header. When the entry's IP flag is set, a 20-byte IPv4 header and an 8-byte UDP header follow. The IPv4 checksum is computed in hardware, and the UDP checksum is left at zero. When the entry's radio-transport flag is set, two 32-bit words follow next:
- a word with the packet type, a per-port rolling count and the size;
- the stream identifier.

The payload comes last. The input is held off while header bytes are being emitted. Software programs the table, the local addresses and the raw ethertype through a simple write port.

Top module: `egress_framer`

## Requirements
- R1: While reset is asserted and right after it, `out_valid` and `in_ready` are 0.
- R2: Ethernet header layout:
  - bytes 0..5 are the entry's destination MAC;
  - bytes 6..11 are the local MAC;
  - bytes 12..13 are 0x0800 when the IP flag is set, and otherwise the programmed raw ethertype.
- R3: IPv4 header layout (IP flag set), in order:
  - 0x45, 0x00;
  - total length = payload + 28, plus 8 more with the radio-transport flag;
  - identification 0 and flags/fragment 0;
  - TTL 64, protocol 17;
  - checksum;
  - local IP, then the entry's destination IP.
- R4: The IPv4 checksum field (frame bytes 24..25) is the ones' complement of the ones' complement sum of the header's 16-bit words.
- R5: UDP header:
  - source port = 1001 + port number;
  - destination port = 1000;
  - length = IPv4 total length − 20;
  - checksum 0x0000.
- R6: Radio-transport word 1 is sent big-endian, with these fields:
  - bits 31:28 = packet type, 0x1 for data or 0x4 when the entry's context bit is set;
  - bits 27:20 = 0;
  - bits 15:0 = 2 + ceil(payload/4).
- R7: Word 1 bits 19:16 carry a 4-bit count per port. The count starts at 0 after reset and wraps from 15 to 0. It advances only on frames whose entry has the radio-transport flag set.
- R8: Radio-transport word 2 is the stream-table entry chosen by the port entry's 2-bit stream selector.
- R9: Headers appear in this order: Ethernet, then IPv4/UDP, then radio-transport. Each disabled header is omitted, so the header is 14, 22, 42 or 50 bytes long.
- R10: `in_ready` stays 0 until the whole header has been emitted. Payload bytes then pass unchanged, and `out_last` marks the final payload byte.
- R11: While `out_valid` is 1 and `out_ready` is 0, `out_valid` and `out_data` hold on the next cycle.
- R12: A write with `cfg_we` stores `cfg_wdata` in the field chosen by `cfg_sel`:
  - 0: control, with vita_en at bit 0, ip_en at bit 1, context at bit 2 and stream selector at bits 5:4;
  - 1: destination MAC[47:32];
  - 2: destination MAC[31:0];
  - 3: destination IP;
  - 4: stream table entry `cfg_port`;
  - 5: local MAC[47:32];
  - 6: local MAC[31:0];
  - 7: local IP;
  - 8: raw ethertype.

  The write applies to frames that start after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_port | input | 2 | Port entry, or stream-table entry, being written |
| cfg_sel | input | 4 | Field selector (see R12) |
| cfg_wdata | input | 32 | Write data |
| in_valid | input | 1 | Payload byte valid |
| in_ready | output | 1 | Payload byte accepted |
| in_data | input | 8 | Payload byte |
| in_last | input | 1 | Final payload byte of the frame |
| in_port | input | 2 | Source port number, held for the whole frame |
| in_len | input | 16 | Payload length in bytes (at least 1), held for the whole frame |
| out_valid | output | 1 | Frame byte valid |
| out_ready | input | 1 | Downstream accepts the byte |
| out_data | output | 8 | Frame byte |
| out_last | output | 1 | Final byte of the frame |

## Verification
Several properties are checked on every cycle:
- output stability under back-pressure;
- the input being held off at the start of every frame and again after the last byte;
- the header length taking only its four legal values;
- the IPv4 checksum summing to all ones against the fields it covers.

Only the bench's scenarios can show that each header byte has the right value and position for every flag combination. The same holds for the per-port count wrapping and staying untouched on other ports' frames, for stream-selector indirection, and for configuration changes taking effect on the following frame.

// File: rtl/egf_pkg.sv
// Shared types and constants of the outbound header formatter.
// Assumes: stream table has 2**SID_W entries; all header fields are big-endian.
package egf_pkg;
    localparam int SID_W = 2;
    localparam int SID_N = 1 << SID_W;
    localparam int HDR_MAX = 64;                 // header byte buffer size (>= 50)
    localparam logic [15:0] ETYPE_IPV4 = 16'h0800;
    localparam logic [7:0]  IP_TTL     = 8'd64;
    localparam logic [7:0]  IP_PROTO   = 8'd17;
    localparam logic [3:0]  VRT_DATA   = 4'h1;
    localparam logic [3:0]  VRT_CTX    = 4'h4;

    typedef enum logic [3:0] {
        SEL_CTRL    = 4'd0,
        SEL_DMAC_HI = 4'd1,
        SEL_DMAC_LO = 4'd2,
        SEL_DIP     = 4'd3,
        SEL_SID     = 4'd4,
        SEL_LMAC_HI = 4'd5,
        SEL_LMAC_LO = 4'd6,
        SEL_LIP     = 4'd7,
        SEL_ETYPE   = 4'd8
    } cfg_sel_e;

    typedef struct packed {
        logic             vita_en;
        logic             ip_en;
        logic             is_ctx;
        logic [SID_W-1:0] sid_sel;
        logic [47:0]      dmac;
        logic [31:0]      dip;
    } port_entry_t;

    typedef enum logic [1:0] {S_IDLE = 2'd0, S_HDR = 2'd1, S_PAY = 2'd2} fsm_e;
endpackage

// File: rtl/egf_cfg_table.sv
// Configuration storage: one entry per port, a stream-ID table, and the
// local MAC, local IP and raw ethertype. It resolves the stream
// selector of the entry being read.
// Assumes: PID_W >= SID_W so cfg_port can address the stream table.
module egf_cfg_table
    import egf_pkg::*;
#(
    parameter int N_PORTS = 4,
    parameter int PID_W   = $clog2(N_PORTS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [PID_W-1:0] wport,
    input  logic [3:0]       wsel,
    input  logic [31:0]      wdata,
    input  logic [PID_W-1:0] rd_port,
    output logic             rd_vita,
    output logic             rd_ip,
    output logic             rd_ctx,
    output logic [47:0]      rd_dmac,
    output logic [31:0]      rd_dip,
    output logic [31:0]      rd_sid,
    output logic [47:0]      lmac,
    output logic [31:0]      lip,
    output logic [15:0]      etype
);
    port_entry_t tbl [N_PORTS];
    logic [31:0] sid_tbl [SID_N];
    port_entry_t cur;

    // Register writes into the table, the stream table and the globals.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N_PORTS; i++) tbl[i] <= '0;
            for (int i = 0; i < SID_N; i++) sid_tbl[i] <= '0;
            lmac  <= '0;
            lip   <= '0;
            etype <= '0;
        end else if (we) begin
            case (cfg_sel_e'(wsel))
                SEL_CTRL: begin
                    tbl[wport].vita_en <= wdata[0];
                    tbl[wport].ip_en   <= wdata[1];
                    tbl[wport].is_ctx  <= wdata[2];
                    tbl[wport].sid_sel <= wdata[4 +: SID_W];
                end
                SEL_DMAC_HI: tbl[wport].dmac[47:32] <= wdata[15:0];
                SEL_DMAC_LO: tbl[wport].dmac[31:0]  <= wdata;
                SEL_DIP:     tbl[wport].dip         <= wdata;
                SEL_SID:     sid_tbl[wport[SID_W-1:0]] <= wdata;
                SEL_LMAC_HI: lmac[47:32] <= wdata[15:0];
                SEL_LMAC_LO: lmac[31:0]  <= wdata;
                SEL_LIP:     lip   <= wdata;
                SEL_ETYPE:   etype <= wdata[15:0];
                default: ;
            endcase
        end
    end

    // Read the selected entry and resolve its stream ID.
    always_comb begin
        cur     = tbl[rd_port];
        rd_vita = cur.vita_en;
        rd_ip   = cur.ip_en;
        rd_ctx  = cur.is_ctx;
        rd_dmac = cur.dmac;
        rd_dip  = cur.dip;
        rd_sid  = sid_tbl[cur.sid_sel];
    end
endmodule

// File: rtl/egf_hdr_gen.sv
// Combinational header builder. From the latched frame parameters it
// assembles the Ethernet, IPv4/UDP and radio-transport headers into a byte
// buffer. It returns the byte at idx, the header length, the IPv4 total
// length and the IPv4 checksum.
// Assumes: payload length plus headers fits in 16 bits.
module egf_hdr_gen
    import egf_pkg::*;
#(
    parameter int          PID_W    = 2,
    parameter logic [15:0] UDP_BASE = 16'd1000
) (
    input  logic             vita_en,
    input  logic             ip_en,
    input  logic             is_ctx,
    input  logic [47:0]      dmac,
    input  logic [31:0]      dip,
    input  logic [31:0]      sid,
    input  logic [3:0]       seq,
    input  logic [15:0]      plen,
    input  logic [PID_W-1:0] pid,
    input  logic [47:0]      lmac,
    input  logic [31:0]      lip,
    input  logic [15:0]      etype,
    input  logic [5:0]       idx,
    output logic [7:0]       hbyte,
    output logic [5:0]       hlen,
    output logic [15:0]      ip_total,
    output logic [15:0]      ip_cksum
);
    logic [15:0]  vlen, udp_len, vwords, sport;
    logic [31:0]  csum;
    logic [16:0]  fold1;
    logic [15:0]  fold2;
    logic [111:0] eth_v;
    logic [223:0] ipu_v;
    logic [63:0]  vrt_v;
    logic [7:0]   hdr [HDR_MAX];
    logic [5:0]   vbase;

    // Length fields derived from the payload length and the enabled headers.
    always_comb begin
        vlen     = plen + (vita_en ? 16'd8 : 16'd0);
        ip_total = vlen + 16'd28;
        udp_len  = vlen + 16'd8;
        vwords   = 16'(({1'b0, plen} + 17'd3) >> 2) + 16'd2;
        sport    = UDP_BASE + 16'd1 + 16'(pid);
    end

    // IPv4 header checksum: ones' complement sum of the non-zero words.
    always_comb begin
        csum = 32'h4500 + 32'(ip_total) + 32'({IP_TTL, IP_PROTO})
             + 32'(lip[31:16]) + 32'(lip[15:0]) + 32'(dip[31:16]) + 32'(dip[15:0]);
        fold1    = 17'(csum[15:0]) + 17'(csum[31:16]);
        fold2    = fold1[15:0] + 16'(fold1[16]);
        ip_cksum = ~fold2;
    end

    // Header field vectors, most significant byte first.
    always_comb begin
        eth_v = {dmac, lmac, (ip_en ? ETYPE_IPV4 : etype)};
        ipu_v = {8'h45, 8'h00, ip_total, 16'h0000, 16'h0000, IP_TTL, IP_PROTO,
                 ip_cksum, lip, dip, sport, UDP_BASE, udp_len, 16'h0000};
        vrt_v = {(is_ctx ? VRT_CTX : VRT_DATA), 8'h00, seq, vwords, sid};
    end

    // Lay the enabled headers back to back and pick the requested byte.
    always_comb begin
        for (int i = 0; i < HDR_MAX; i++) hdr[i] = 8'h00;
        for (int i = 0; i < 14; i++) hdr[i] = eth_v[111 - 8*i -: 8];
        if (ip_en)
            for (int i = 0; i < 28; i++) hdr[14 + i] = ipu_v[223 - 8*i -: 8];
        vbase = ip_en ? 6'd42 : 6'd14;
        if (vita_en)
            for (int i = 0; i < 8; i++) hdr[6'(vbase + 6'(i))] = vrt_v[63 - 8*i -: 8];
        hlen  = 6'd14 + (ip_en ? 6'd28 : 6'd0) + (vita_en ? 6'd8 : 6'd0);
        hbyte = hdr[idx];
    end
endmodule

// File: rtl/egress_framer.sv
// Outbound header formatter top. At the start of each frame it reads the
// port's entry and latches every header parameter. It emits the header
// bytes with the input held off, then passes the payload through.
// Assumes: in_port and in_len are stable from the first in_valid until the
// last payload byte is accepted; in_len >= 1; the input holds its byte
// while in_ready is low.
module egress_framer
    import egf_pkg::*;
#(
    parameter int          N_PORTS  = 4,
    parameter int          LEN_W    = 16,
    parameter logic [15:0] UDP_BASE = 16'd1000,
    localparam int         PID_W    = $clog2(N_PORTS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [PID_W-1:0] cfg_port,
    input  logic [3:0]       cfg_sel,
    input  logic [31:0]      cfg_wdata,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [7:0]       in_data,
    input  logic             in_last,
    input  logic [PID_W-1:0] in_port,
    input  logic [LEN_W-1:0] in_len,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [7:0]       out_data,
    output logic             out_last
);
    fsm_e             state;
    logic [5:0]       idx;
    logic [3:0]       seq_cnt [N_PORTS];

    logic             rd_vita, rd_ip, rd_ctx;
    logic [47:0]      rd_dmac, lmac;
    logic [31:0]      rd_dip, rd_sid, lip;
    logic [15:0]      etype;

    logic             l_vita, l_ip, l_ctx;
    logic [47:0]      l_dmac, l_lmac;
    logic [31:0]      l_dip, l_sid, l_lip;
    logic [15:0]      l_etype;
    logic [3:0]       l_seq;
    logic [LEN_W-1:0] l_len;
    logic [PID_W-1:0] l_pid;

    logic [7:0]       hbyte;
    logic [5:0]       hlen;
    logic [15:0]      ip_total, ip_cksum;

    egf_cfg_table #(.N_PORTS(N_PORTS), .PID_W(PID_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .wport(cfg_port), .wsel(cfg_sel),
        .wdata(cfg_wdata), .rd_port(in_port), .rd_vita(rd_vita), .rd_ip(rd_ip),
        .rd_ctx(rd_ctx), .rd_dmac(rd_dmac), .rd_dip(rd_dip), .rd_sid(rd_sid),
        .lmac(lmac), .lip(lip), .etype(etype)
    );

    egf_hdr_gen #(.PID_W(PID_W), .UDP_BASE(UDP_BASE)) u_hdr (
        .vita_en(l_vita), .ip_en(l_ip), .is_ctx(l_ctx), .dmac(l_dmac), .dip(l_dip),
        .sid(l_sid), .seq(l_seq), .plen(16'(l_len)), .pid(l_pid), .lmac(l_lmac),
        .lip(l_lip), .etype(l_etype), .idx(idx), .hbyte(hbyte), .hlen(hlen),
        .ip_total(ip_total), .ip_cksum(ip_cksum)
    );

    // Frame sequencer: latch parameters, walk the header, then pass the payload.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE;
            idx   <= '0;
            for (int i = 0; i < N_PORTS; i++) seq_cnt[i] <= '0;
            {l_vita, l_ip, l_ctx} <= '0;
            l_dmac <= '0; l_lmac <= '0; l_dip <= '0; l_sid <= '0; l_lip <= '0;
            l_etype <= '0; l_seq <= '0; l_len <= '0; l_pid <= '0;
        end else begin
            case (state)
                S_IDLE: if (in_valid) begin
                    l_vita  <= rd_vita;
                    l_ip    <= rd_ip;
                    l_ctx   <= rd_ctx;
                    l_dmac  <= rd_dmac;
                    l_dip   <= rd_dip;
                    l_sid   <= rd_sid;
                    l_lmac  <= lmac;
                    l_lip   <= lip;
                    l_etype <= etype;
                    l_seq   <= seq_cnt[in_port];
                    l_len   <= in_len;
                    l_pid   <= in_port;
                    if (rd_vita) seq_cnt[in_port] <= seq_cnt[in_port] + 4'd1;
                    idx     <= '0;
                    state   <= S_HDR;
                end
                S_HDR: if (out_ready) begin
                    if (idx == hlen - 6'd1) state <= S_PAY;
                    else                    idx   <= idx + 6'd1;
                end
                S_PAY: if (in_valid && out_ready && in_last) state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end

    // Output mux and input back-pressure.
    always_comb begin
        out_valid = (state == S_HDR) || (state == S_PAY && in_valid);
        out_data  = (state == S_HDR) ? hbyte : in_data;
        out_last  = (state == S_PAY) && in_last;
        in_ready  = (state == S_PAY) && out_ready;
    end

    // Independent ones' complement verification of the emitted checksum.
    logic [31:0] vsum;
    logic [16:0] vf1;
    logic [15:0] vf2;
    always_comb begin
        vsum = 32'h4500 + 32'(ip_total) + 32'h4011 + 32'(l_lip[31:16]) + 32'(l_lip[15:0])
             + 32'(l_dip[31:16]) + 32'(l_dip[15:0]) + 32'(ip_cksum);
        vf1  = 17'(vsum[15:0]) + 17'(vsum[31:16]);
        vf2  = vf1[15:0] + 16'(vf1[16]);
    end

    a_r11_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    a_r10_hdr_first: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && in_valid) |=> !in_ready);

    a_r10_last_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_last) |=> !in_ready);

    a_r9_hdr_len: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_HDR) |-> (hlen == 6'd14 || hlen == 6'd22 || hlen == 6'd42 || hlen == 6'd50));

    a_r4_cksum_ok: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_HDR && l_ip) |-> (vf2 == 16'hFFFF));
endmodule

// File: tb/sim_egress_framer.sv
module sim_egress_framer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_port = '0;
    logic [3:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [7:0]  in_data = '0;
    logic        in_last = 1'b0;
    logic [1:0]  in_port = '0;
    logic [15:0] in_len = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [7:0]  out_data;
    logic        out_last;

    always #10 clk = ~clk;

    egress_framer u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_port(cfg_port), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .in_last(in_last), .in_port(in_port), .in_len(in_len), .out_valid(out_valid),
        .out_ready(out_ready), .out_data(out_data), .out_last(out_last)
    );

    int n_vec = 0;
    int n_bad = 0;
    bit mon_on = 0;
    bit bp_mode = 0;
    int cyc = 0;

    // Behavioural mirror of the configuration and per-port counters.
    bit          m_vita [4], m_ip [4], m_ctx [4];
    int          m_sel [4];
    logic [47:0] m_dmac [4];
    logic [31:0] m_dip [4], m_sid [4];
    logic [47:0] m_lmac;
    logic [31:0] m_lip;
    logic [15:0] m_etype;
    int          m_cnt [4];

    // Expected output stream.
    byte unsigned exp_d [$];
    bit           exp_l [$];
    bit           exp_p [$];
    string        exp_t [$];

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h (t=%0t)", tag, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    task automatic wr(input int port, input int sel, input logic [31:0] d);
        @(posedge clk); #1;
        cfg_we = 1'b1; cfg_port = 2'(port); cfg_sel = 4'(sel); cfg_wdata = d;
        @(posedge clk); #1;
        cfg_we = 1'b0;
    endtask

    // R12: program one port entry through the write port and mirror it.
    task automatic set_port(input int p, input bit v, input bit ip, input bit ctx, input int sel,
                            input logic [47:0] dmac, input logic [31:0] dip);
        wr(p, 0, {26'd0, 2'(sel), 1'b0, ctx, ip, v});
        wr(p, 1, {16'd0, dmac[47:32]});
        wr(p, 2, dmac[31:0]);
        wr(p, 3, dip);
        m_vita[p] = v; m_ip[p] = ip; m_ctx[p] = ctx; m_sel[p] = sel;
        m_dmac[p] = dmac; m_dip[p] = dip;
    endtask

    function automatic void push(input byte unsigned d, input bit l, input bit p, input string t);
        exp_d.push_back(d); exp_l.push_back(l); exp_p.push_back(p); exp_t.push_back(t);
    endfunction

    function automatic byte unsigned pay(input int seed, input int i);
        return byte'((seed + i * 7) & 8'hFF);
    endfunction

    // Reference frame builder from the requirements.
    function automatic void model_frame(input int p, input int len, input int seed);
        byte unsigned ih [20];
        int tot, s, words, typ, cnt;
        for (int i = 0; i < 6; i++) push(m_dmac[p][47 - 8*i -: 8], 0, 0, "R2");
        for (int i = 0; i < 6; i++) push(m_lmac[47 - 8*i -: 8], 0, 0, "R2");
        if (m_ip[p]) begin push(8'h08, 0, 0, "R2"); push(8'h00, 0, 0, "R2"); end
        else begin push(m_etype[15:8], 0, 0, "R2"); push(m_etype[7:0], 0, 0, "R2"); end
        if (m_ip[p]) begin
            tot = len + 28 + (m_vita[p] ? 8 : 0);
            ih = '{8'h45, 8'h00, byte'(tot >> 8), byte'(tot), 0, 0, 0, 0, 64, 17, 0, 0,
                   m_lip[31:24], m_lip[23:16], m_lip[15:8], m_lip[7:0],
                   m_dip[p][31:24], m_dip[p][23:16], m_dip[p][15:8], m_dip[p][7:0]};
            s = 0;
            for (int i = 0; i < 20; i += 2) s += ih[i] * 256 + ih[i+1];
            while (s > 16'hFFFF) s = (s & 16'hFFFF) + (s >> 16);
            s = (~s) & 16'hFFFF;
            ih[10] = byte'(s >> 8); ih[11] = byte'(s);
            for (int i = 0; i < 20; i++) push(ih[i], 0, 0, (i == 10 || i == 11) ? "R4" : "R3");
            push(byte'((1001 + p) >> 8), 0, 0, "R5"); push(byte'(1001 + p), 0, 0, "R5");
            push(8'h03, 0, 0, "R5"); push(8'hE8, 0, 0, "R5");
            push(byte'((tot - 20) >> 8), 0, 0, "R5"); push(byte'(tot - 20), 0, 0, "R5");
            push(0, 0, 0, "R5"); push(0, 0, 0, "R5");
        end
        if (m_vita[p]) begin
            words = 2 + (len + 3) / 4;
            typ = m_ctx[p] ? 4 : 1;
            cnt = m_cnt[p];
            m_cnt[p] = (m_cnt[p] + 1) % 16;
            push(byte'(typ << 4), 0, 0, "R6");
            push(byte'(cnt), 0, 0, "R7");
            push(byte'(words >> 8), 0, 0, "R6"); push(byte'(words), 0, 0, "R6");
            for (int i = 0; i < 4; i++) push(m_sid[m_sel[p]][31 - 8*i -: 8], 0, 0, "R8");
        end
        for (int i = 0; i < len; i++) push(pay(seed, i), (i == len - 1), 1, "R10");
    endfunction

    task automatic send(input int p, input int len, input int seed);
        model_frame(p, len, seed);
        @(posedge clk); #1;
        in_port = 2'(p); in_len = 16'(len);
        for (int i = 0; i < len; i++) begin
            in_valid = 1'b1; in_data = pay(seed, i); in_last = (i == len - 1);
            @(negedge clk);
            while (!in_ready) @(negedge clk);
            @(posedge clk); #1;
        end
        in_valid = 1'b0; in_last = 1'b0;
    endtask

    // Output ready pattern, changed away from the sampling edge.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        #1 out_ready = bp_mode ? ((cyc % 3) != 2) : 1'b1;
    end

    // Monitor: compare each accepted byte; check stall hold and input hold-off.
    bit       prev_stall = 0;
    bit [7:0] prev_data = 0;
    always @(negedge clk) begin
        if (mon_on) begin
            if (prev_stall) begin
                check(out_valid === 1'b1, "R11 valid hold", int'(out_valid), 1);
                check(out_data === prev_data, "R11 data hold", int'(out_data), int'(prev_data));
            end
            if (out_valid && exp_p.size() > 0 && exp_p[0] == 0)
                check(in_ready === 1'b0, "R10 hold-off during header", int'(in_ready), 0);
            if (out_valid && out_ready) begin
                if (exp_d.size() == 0) check(0, "R9 extra byte", int'(out_data), -1);
                else begin
                    check(out_data === exp_d[0], exp_t[0], int'(out_data), int'(exp_d[0]));
                    check(out_last === exp_l[0], {exp_t[0], " last"}, int'(out_last), int'(exp_l[0]));
                    void'(exp_d.pop_front()); void'(exp_l.pop_front());
                    void'(exp_p.pop_front()); void'(exp_t.pop_front());
                end
            end
            prev_stall = out_valid && !out_ready;
            prev_data  = out_data;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        check(0, "watchdog expired", 0, 1);
        summary();
    end

    initial begin
        for (int i = 0; i < 4; i++) begin
            m_vita[i] = 0; m_ip[i] = 0; m_ctx[i] = 0; m_sel[i] = 0;
            m_dmac[i] = '0; m_dip[i] = '0; m_sid[i] = '0; m_cnt[i] = 0;
        end
        m_lmac = '0; m_lip = '0; m_etype = '0;
        repeat (3) @(negedge clk);
        check(out_valid === 1'b0, "R1 out_valid in reset", int'(out_valid), 0);
        check(in_ready === 1'b0, "R1 in_ready in reset", int'(in_ready), 0);
        @(posedge clk); #1 rst_n = 1'b1;
        @(negedge clk);
        check(out_valid === 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
        check(in_ready === 1'b0, "R1 in_ready after reset", int'(in_ready), 0);
        mon_on = 1;

        // R12: globals and stream table.
        wr(0, 5, 32'h0000_0A1B); wr(0, 6, 32'h2C3D_4E5F); m_lmac = 48'h0A1B_2C3D_4E5F;
        wr(0, 7, 32'hC0A8_0101); m_lip = 32'hC0A8_0101;
        wr(0, 8, 32'h0000_88B5); m_etype = 16'h88B5;
        for (int i = 0; i < 4; i++) begin
            wr(i, 4, 32'h5100_0000 + 32'(i) * 32'h0101_0101);
            m_sid[i] = 32'h5100_0000 + 32'(i) * 32'h0101_0101;
        end
        set_port(0, 1, 1, 0, 2, 48'h0011_2233_4455, 32'h0A00_0002);
        set_port(1, 0, 1, 0, 0, 48'hFFFF_FFFF_FFFF, 32'hFFFF_FFFF);
        set_port(2, 1, 0, 1, 3, 48'h6677_8899_AABB, 32'h0);
        set_port(3, 0, 0, 0, 1, 48'h0102_0304_0506, 32'h0);

        // All four flag combinations, then sizes not a multiple of four (R6, R9).
        send(0, 5, 16); send(1, 3, 40); send(2, 8, 80); send(3, 1, 99);
        send(0, 1, 3); send(0, 4, 7); send(2, 13, 5);
        // Back-pressure on the output (R11).
        bp_mode = 1;
        send(0, 9, 33); send(1, 6, 12); send(2, 2, 70); send(3, 4, 1);
        bp_mode = 0;
        // R7: wrap port 2's count past 15; port 1/3 frames leave counters alone.
        for (int k = 0; k < 17; k++) begin
            send(2, 1, k);
            if (k % 5 == 0) send(1, 1, k);
        end
        // R8/R12: re-point port 0 to another stream entry and disable IP.
        set_port(0, 1, 0, 1, 1, 48'hDEAD_BEEF_0001, 32'h0);
        send(0, 6, 200);
        wr(0, 8, 32'h0000_1234); m_etype = 16'h1234;
        send(3, 2, 9);
        repeat (10) @(negedge clk);
        check(exp_d.size() == 0, "R9 all expected bytes emitted", exp_d.size(), 0);
        summary();
    end
endmodule